// File: doc/BRIEF.md
# Clock and Power Control Register Unit

This block is a small register file on a device-control register bus. It holds the chip's clock configuration. The bus gives a single-cycle read or write strobe, a 10-bit register number and 32-bit data. The unit keeps these registers:

- a PLL mode word
- two control words
- a captured copy of the configuration strap pins
- a fixed identification word
- clock-enable and clock-force words
- a status word derived from the enable and force words

Each writable register applies its own write mask. Read data is registered and appears on the cycle after the read strobe.

While the synchronous reset is held, the unit samples the strap pins. In the same cycle it builds the PLL mode reset word from those straps, decoding each field separately. The ratio outputs are derived from the live register contents. They give the CPU clock multiple of the reference, the timer clock source, the divider for the processor-local bus, the peripheral bus, the external bus and the serial port, and a flag that the PLL is in use and locked.

The lock check multiplies the reference frequency, in MHz, by the total loop multiplier. If the result falls outside the VCO window, the PLL enable bit of the mode word is cleared on the next cycle, and the clocks are derived in bypass.

Top module: `clkctl_regs`

## Requirements
- R1: Register numbers are 0x0B0 PLL mode, 0x0B1 control A, 0x0B2 control B, 0x0B4 strap copy, 0x0B5 ID, 0x0B9 enable, 0x0BA force, 0x0BB status. Read data appears on the cycle after the read strobe, and any other number reads as 0.
- R2: Writes are masked: PLL mode by 0xFFF77C3F, control A by 0x0FFFFFFE, control B by 0x00800000, and both enable and force by 0xBFFC0000.
- R3: Writes to the strap copy, ID and status registers are ignored. ID always reads 0x42051049.
- R4: Status reads as ~(enable | force) & 0xFFFF0000.
- R5: After reset, control A = 0x0000003C, control B = 0x2B0D8800, and enable = force = 0.
- R6: The strap copy holds the strap pins as they were at the last reset cycle. Strap changes after reset are ignored.
- R7: The PLL mode reset word starts at 0x80000000. Strap[31:30] selects the forward divider: 0 clears bit 31, 1 puts 5 into [18:16], 2 puts 4 there, and 3 puts 2 there.
- R8: In the reset word, strap[29:28]+1 goes to [22:20], strap[24:23] to [27:26], strap[22:21] to [11:10] and strap[18:17] to [25:24]. Strap[27:25] equal to 2, 4 or 5 ORs in 0x13, 0x15 or 0x16 respectively.
- R9: The bus divider D0 is mode[27:26]+1. The peripheral-bus divider is mode[11:10]+1, the external-bus divider is mode[25:24]+2, and the serial divider is control A[5:1]+1.
- R10: With mode bit 31 set, the loop multiplier is D0·D1·D2, where D1 = mode[23:20] (0 means 16) and D2 = 8−mode[18:16]. If ref_mhz times the multiplier lies outside 400..800, bit 31 is cleared on the next cycle and the lock flag is 0.
- R11: The CPU clock multiple is D0·D1 when locked and D0 in bypass.
- R12: The timer source output is 1 (reference clock) exactly when control B bit 23 is set.
- R13: A bus write to PLL mode in the same cycle as a pending lock-range clear stores the written value, and the clear does not apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_in | input | 32 | Configuration strap pins |
| ref_mhz | input | 10 | Reference clock frequency in MHz |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_num | input | 10 | Register number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_mult | output | 7 | CPU clock as a multiple of the reference |
| tmr_ref_sel | output | 1 | Timer uses the reference clock |
| plb_div | output | 3 | Local bus divider from the CPU clock |
| opb_div | output | 3 | Peripheral bus divider from the local bus |
| ext_div | output | 3 | External bus divider from the local bus |
| uart_div | output | 6 | Serial clock divider from the CPU clock |
| pll_locked | output | 1 | PLL enabled and VCO in range |

## Verification
Two actions can fall on the same clock edge: a bus write to the PLL mode word, and the automatic clearing of its enable bit when the lock check fails. The bench provokes this by raising the reference frequency while the unit is locked, so that the old word goes out of range. On that same edge it writes a new word whose VCO lands in range. The read-back must show the written value with bit 31 still set and the lock flag high. If the clear won, bit 31 would read as 0.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DW = 32;
  localparam int NW = 10;

  localparam logic [NW-1:0] N_PLL    = 10'h0B0;
  localparam logic [NW-1:0] N_CTLA   = 10'h0B1;
  localparam logic [NW-1:0] N_CTLB   = 10'h0B2;
  localparam logic [NW-1:0] N_STRAP  = 10'h0B4;
  localparam logic [NW-1:0] N_ID     = 10'h0B5;
  localparam logic [NW-1:0] N_ENA    = 10'h0B9;
  localparam logic [NW-1:0] N_FRC    = 10'h0BA;
  localparam logic [NW-1:0] N_STAT   = 10'h0BB;

  localparam logic [DW-1:0] M_PLL    = 32'hFFF7_7C3F;
  localparam logic [DW-1:0] M_CTLA   = 32'h0FFF_FFFE;
  localparam logic [DW-1:0] M_CTLB   = 32'h0080_0000;
  localparam logic [DW-1:0] M_GATE   = 32'hBFFC_0000;
  localparam logic [DW-1:0] M_STAT   = 32'hFFFF_0000;

  localparam logic [DW-1:0] RV_CTLA  = 32'h0000_003C;
  localparam logic [DW-1:0] RV_CTLB  = 32'h2B0D_8800;
  localparam logic [DW-1:0] ID_WORD  = 32'h4205_1049;

  typedef struct packed {
    logic [6:0] cpu_mult;
    logic       tmr_ref;
    logic [2:0] plb_div;
    logic [2:0] opb_div;
    logic [2:0] ext_div;
    logic [5:0] uart_div;
    logic       locked;
  } ratio_t;
endpackage

// File: rtl/clkctl_strap_decode.sv
module clkctl_strap_decode
  import clkctl_pkg::*;
(
  input  logic [DW-1:0] strap,
  output logic [DW-1:0] pll_init
);
  always_comb begin
    pll_init = 32'h8000_0000;
    unique case (strap[31:30])
      2'd0: pll_init[31]    = 1'b0;
      2'd1: pll_init[18:16] = 3'd5;
      2'd2: pll_init[18:16] = 3'd4;
      default: pll_init[18:16] = 3'd2;
    endcase
    pll_init[22:20] = {1'b0, strap[29:28]} + 3'd1;
    case (strap[27:25])
      3'd2:    pll_init = pll_init | 32'h13;
      3'd4:    pll_init = pll_init | 32'h15;
      3'd5:    pll_init = pll_init | 32'h16;
      default: pll_init = pll_init;
    endcase
    pll_init[27:26] = strap[24:23];
    pll_init[11:10] = strap[22:21];
    pll_init[25:24] = strap[18:17];
  end
endmodule

// File: rtl/clkctl_ratio.sv
module clkctl_ratio
  import clkctl_pkg::*;
#(
  parameter int REF_W   = 10,
  parameter int VCO_MIN = 400,
  parameter int VCO_MAX = 800
) (
  input  logic [DW-1:0]    pll_word,
  input  logic [DW-1:0]    ctla,
  input  logic [DW-1:0]    ctlb,
  input  logic [REF_W-1:0] ref_mhz,
  output logic             vco_ok,
  output ratio_t           ratio
);
  localparam int MUL_W = 10;
  localparam int VCO_W = REF_W + MUL_W;

  logic [2:0]       d0;
  logic [4:0]       d1;
  logic [3:0]       d2;
  logic [MUL_W-1:0] mul;
  logic [VCO_W-1:0] vco;

  always_comb begin
    d0  = {1'b0, pll_word[27:26]} + 3'd1;
    d1  = (pll_word[23:20] == 4'd0) ? 5'd16 : {1'b0, pll_word[23:20]};
    d2  = 4'd8 - {1'b0, pll_word[18:16]};
    mul = MUL_W'(d0) * MUL_W'(d1) * MUL_W'(d2);
    vco = VCO_W'(ref_mhz) * VCO_W'(mul);
    vco_ok = (vco >= VCO_W'(VCO_MIN)) && (vco <= VCO_W'(VCO_MAX));

    ratio.locked   = pll_word[31] && vco_ok;
    ratio.cpu_mult = ratio.locked ? (7'(d0) * 7'(d1)) : 7'(d0);
    ratio.tmr_ref  = ctlb[23];
    ratio.plb_div  = d0;
    ratio.opb_div  = {1'b0, pll_word[11:10]} + 3'd1;
    ratio.ext_div  = {1'b0, pll_word[25:24]} + 3'd2;
    ratio.uart_div = {1'b0, ctla[5:1]} + 6'd1;
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int REF_W   = 10,
  parameter int VCO_MIN = 400,
  parameter int VCO_MAX = 800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      strap_in,
  input  logic [REF_W-1:0] ref_mhz,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [9:0]       bus_num,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [6:0]       cpu_mult,
  output logic             tmr_ref_sel,
  output logic [2:0]       plb_div,
  output logic [2:0]       opb_div,
  output logic [2:0]       ext_div,
  output logic [5:0]       uart_div,
  output logic             pll_locked
);
  logic [DW-1:0] pll_q, ctla_q, ctlb_q, strap_q, ena_q, frc_q;
  logic [DW-1:0] pll_init, rd_mux, stat_w;
  logic          vco_ok, clear_pll;
  ratio_t        ratio_c, ratio_q;

  clkctl_strap_decode u_decode (
    .strap    (strap_in),
    .pll_init (pll_init)
  );

  clkctl_ratio #(
    .REF_W   (REF_W),
    .VCO_MIN (VCO_MIN),
    .VCO_MAX (VCO_MAX)
  ) u_ratio (
    .pll_word (pll_q),
    .ctla     (ctla_q),
    .ctlb     (ctlb_q),
    .ref_mhz  (ref_mhz),
    .vco_ok   (vco_ok),
    .ratio    (ratio_c)
  );

  assign clear_pll = pll_q[31] && !vco_ok;
  assign stat_w    = ~(ena_q | frc_q) & M_STAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= strap_in;
      pll_q   <= pll_init;
      ctla_q  <= RV_CTLA;
      ctlb_q  <= RV_CTLB;
      ena_q   <= '0;
      frc_q   <= '0;
    end else begin
      if (bus_wr && bus_num == N_PLL) pll_q <= bus_wdata & M_PLL;
      else if (clear_pll)             pll_q[31] <= 1'b0;
      if (bus_wr && bus_num == N_CTLA) ctla_q <= bus_wdata & M_CTLA;
      if (bus_wr && bus_num == N_CTLB) ctlb_q <= bus_wdata & M_CTLB;
      if (bus_wr && bus_num == N_ENA)  ena_q  <= bus_wdata & M_GATE;
      if (bus_wr && bus_num == N_FRC)  frc_q  <= bus_wdata & M_GATE;
    end
  end

  always_comb begin
    unique case (bus_num)
      N_PLL:   rd_mux = pll_q;
      N_CTLA:  rd_mux = ctla_q;
      N_CTLB:  rd_mux = ctlb_q;
      N_STRAP: rd_mux = strap_q;
      N_ID:    rd_mux = ID_WORD;
      N_ENA:   rd_mux = ena_q;
      N_FRC:   rd_mux = frc_q;
      N_STAT:  rd_mux = stat_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    ratio_q <= ratio_c;
  end

  assign cpu_mult    = ratio_q.cpu_mult;
  assign tmr_ref_sel = ratio_q.tmr_ref;
  assign plb_div     = ratio_q.plb_div;
  assign opb_div     = ratio_q.opb_div;
  assign ext_div     = ratio_q.ext_div;
  assign uart_div    = ratio_q.uart_div;
  assign pll_locked  = ratio_q.locked;
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk
  import clkctl_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [9:0]    bus_num,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          pll_locked,
  input logic [DW-1:0] pll_q,
  input logic [DW-1:0] strap_q,
  input logic          vco_ok
);
  logic mapped;
  assign mapped = (bus_num == N_PLL) || (bus_num == N_CTLA) || (bus_num == N_CTLB) ||
                  (bus_num == N_STRAP) || (bus_num == N_ID) || (bus_num == N_ENA) ||
                  (bus_num == N_FRC) || (bus_num == N_STAT);

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == 32'h0));

  p_id_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_num == N_ID) |=> (bus_rdata == 32'h4205_1049));

  p_status_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_num == N_STAT) |=> (bus_rdata[15:0] == 16'h0));

  p_strap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(strap_q));

  p_lock_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
    pll_locked |-> $past(pll_q[31]));

  p_out_of_range_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (pll_q[31] && !vco_ok && !(bus_wr && bus_num == N_PLL)) |=> !pll_q[31]);

  p_write_wins_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_num == N_PLL) |=> (pll_q == ($past(bus_wdata) & 32'hFFF7_7C3F)));
endmodule

bind clkctl_regs clkctl_regs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_num    (bus_num),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pll_locked (pll_locked),
  .pll_q      (pll_q),
  .strap_q    (strap_q),
  .vco_ok     (vco_ok)
);

// File: tb/clkctl_regs_bench.sv
`timescale 1ns/1ps
module clkctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] strap_in = 32'h9AA4_0000;
  logic [9:0]  ref_mhz = 10'd33;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_num = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  cpu_mult;
  logic        tmr_ref_sel, pll_locked;
  logic [2:0]  plb_div, opb_div, ext_div;
  logic [5:0]  uart_div;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  clkctl_regs u_clkctl_regs (
    .clk(clk), .rst(rst), .strap_in(strap_in), .ref_mhz(ref_mhz),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_num(bus_num), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_mult(cpu_mult), .tmr_ref_sel(tmr_ref_sel),
    .plb_div(plb_div), .opb_div(opb_div), .ext_div(ext_div),
    .uart_div(uart_div), .pll_locked(pll_locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk);
    rst = 1'b1; strap_in = s;
    repeat (2) @(negedge clk);
    rst = 1'b0; strap_in = ~s;
    repeat (3) @(negedge clk);
  endtask

  task automatic bwrite(input logic [9:0] n, input logic [31:0] d);
    bus_wr = 1'b1; bus_num = n; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [9:0] n, output logic [31:0] d);
    bus_rd = 1'b1; bus_num = n;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset(32'h9AA4_0000);
    bread(10'h0B0, d); chk("R7 pll reset word", d, 32'h8624_0416);
    bread(10'h0B4, d); chk("R6 strap copy", d, 32'h9AA4_0000);
    bread(10'h0B1, d); chk("R5 ctla reset", d, 32'h0000_003C);
    bread(10'h0B2, d); chk("R5 ctlb reset", d, 32'h2B0D_8800);
    bread(10'h0B9, d); chk("R5 enable reset", d, 32'h0);
    bread(10'h0BA, d); chk("R5 force reset", d, 32'h0);
    bread(10'h0B5, d); chk("R3 id", d, 32'h4205_1049);
    bread(10'h0BB, d); chk("R4 status reset", d, 32'hFFFF_0000);
    bread(10'h0B3, d); chk("R1 unmapped", d, 32'h0);
    bread(10'h3FF, d); chk("R1 unmapped high", d, 32'h0);
    chk("R11 cpu mult locked", 32'(cpu_mult), 32'd4);
    chk("R10 locked", 32'(pll_locked), 32'd1);
    chk("R9 plb div", 32'(plb_div), 32'd2);
    chk("R9 opb div", 32'(opb_div), 32'd2);
    chk("R9 ext div", 32'(ext_div), 32'd4);
    chk("R9 uart div", 32'(uart_div), 32'd31);
    chk("R12 timer sel clear", 32'(tmr_ref_sel), 32'd0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    bwrite(10'h0B9, 32'hFFFF_FFFF);
    bread(10'h0B9, d); chk("R2 enable mask", d, 32'hBFFC_0000);
    bread(10'h0BB, d); chk("R4 status from enable", d, 32'h4003_0000);
    bwrite(10'h0BA, 32'h4003_0000);
    bread(10'h0BA, d); chk("R2 force mask", d, 32'h0);
    bwrite(10'h0B9, 32'h0);
    bwrite(10'h0BA, 32'h8004_0000);
    bread(10'h0BB, d); chk("R4 status from force", d, 32'h7FFB_0000);
    bwrite(10'h0B1, 32'hFFFF_FFFF);
    bread(10'h0B1, d); chk("R2 ctla mask", d, 32'h0FFF_FFFE);
    bwrite(10'h0B2, 32'hFFFF_FFFF);
    bread(10'h0B2, d); chk("R2 ctlb mask", d, 32'h0080_0000);
    @(negedge clk);
    chk("R9 uart div max", 32'(uart_div), 32'd32);
    chk("R12 timer sel set", 32'(tmr_ref_sel), 32'd1);
    bwrite(10'h0B4, 32'h1234_5678);
    bwrite(10'h0B5, 32'h0);
    bwrite(10'h0BB, 32'h0);
    bread(10'h0B4, d); chk("R3 strap ro", d, 32'h9AA4_0000);
    bread(10'h0B5, d); chk("R3 id ro", d, 32'h4205_1049);
    bread(10'h0BB, d); chk("R3 status ro", d, 32'h7FFB_0000);
    bwrite(10'h0B0, 32'hFFFF_FFFF);
    @(negedge clk);
    bread(10'h0B0, d); chk("R2 pll mask then unlock", d, 32'h7FF7_7C3F);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset(32'h9AA4_0000);
    ref_mhz = 10'd100;
    repeat (3) @(negedge clk);
    bread(10'h0B0, d); chk("R10 high vco clears", d, 32'h0624_0416);
    chk("R10 lock low", 32'(pll_locked), 32'd0);
    chk("R11 bypass mult", 32'(cpu_mult), 32'd2);
    ref_mhz = 10'd25;
    bwrite(10'h0B0, 32'h8624_0416);
    repeat (3) @(negedge clk);
    bread(10'h0B0, d); chk("R10 vco 400 keeps", d, 32'h8624_0416);
    chk("R10 lock at 400", 32'(pll_locked), 32'd1);
    ref_mhz = 10'd50;
    repeat (3) @(negedge clk);
    chk("R10 lock at 800", 32'(pll_locked), 32'd1);
    ref_mhz = 10'd51;
    repeat (3) @(negedge clk);
    chk("R10 unlock at 816", 32'(pll_locked), 32'd0);
    ref_mhz = 10'd24;
    bwrite(10'h0B0, 32'h8624_0416);
    repeat (3) @(negedge clk);
    bread(10'h0B0, d); chk("R10 vco 384 clears", d, 32'h0624_0416);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    ref_mhz = 10'd33;
    do_reset(32'h9AA4_0000);
    ref_mhz = 10'd100;
    bwrite(10'h0B0, 32'h8614_0416);
    repeat (2) @(negedge clk);
    bread(10'h0B0, d); chk("R13 write beats clear", d, 32'h8614_0416);
    chk("R13 locked after write", 32'(pll_locked), 32'd1);
    chk("R11 mult d0*d1", 32'(cpu_mult), 32'd2);
  endtask

  task automatic t_straps();
    logic [31:0] d;
    ref_mhz = 10'd33;
    do_reset(32'h0000_0000);
    bread(10'h0B0, d); chk("R7 straps zero bypass", d, 32'h0010_0000);
    chk("R11 bypass d0 one", 32'(cpu_mult), 32'd1);
    ref_mhz = 10'd150;
    do_reset(32'h4400_0000);
    bread(10'h0B0, d); chk("R8 fwd 5 table 13", d, 32'h8015_0013);
    chk("R10 lock 450", 32'(pll_locked), 32'd1);
    ref_mhz = 10'd100;
    do_reset(32'hC800_0000);
    bread(10'h0B0, d); chk("R8 fwd 2 table 15", d, 32'h8012_0015);
    chk("R11 mult one", 32'(cpu_mult), 32'd1);
    do_reset(32'h01E6_0000);
    bread(10'h0B0, d); chk("R8 field placement", d, 32'h0F10_0C00);
    bread(10'h0B4, d); chk("R6 strap ignores later pins", d, 32'h01E6_0000);
    chk("R9 plb div 4", 32'(plb_div), 32'd4);
    chk("R9 opb div 4", 32'(opb_div), 32'd4);
    chk("R9 ext div 5", 32'(ext_div), 32'd5);
    chk("R11 bypass mult 4", 32'(cpu_mult), 32'd4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_masks();
    t_lock();
    t_collide();
    t_straps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule